// File: doc/BRIEF.md
# Issue Port Allocator with Paired Units

This block sits after dispatch and gives issue ports to a group of up to eight operations. Each operation arrives with a small request code. The code states which ports it needs from a fixed pool:

- four execution ports
- two load ports
- two store ports

Most codes ask for one port of one kind. Other codes ask for one of these:

- a locked pair of execution ports (0+1 or 2+3)
- both store ports at once
- a load port and a store port together, in the same cycle

Branch and synchronisation operations are encoded as single-store-port requests.

An accepted group is held in an eight-entry window. Slot index is the operation's age: slot 0 is the oldest. Every cycle the allocator walks the held operations from oldest to youngest. Each operation takes the lowest-numbered free ports that satisfy it. An operation that cannot be satisfied takes nothing and stays in its slot for the next cycle. A younger operation may still use ports that the older operations left free.

A new group is accepted only in a cycle in which every held operation is being granted. For each granted operation the block reports one or two port indices, so that the booking of ports can be checked from outside.

Top module: `ipa_top`

## Requirements
- R1: While reset is asserted and right after it, no operation is granted and `grp_ready` is 1.
- R2: A group is loaded when `grp_ready` is 1 and any `grp_vld` bit is set. Its operations become grant candidates in the next cycle. An operation whose valid bit was 0 is never granted. `grp_ready` is 1 exactly when every held operation is granted in the current cycle.
- R3: Code 0 (and the spare codes 6 and 7) takes the lowest-numbered free execution port. `gnt_pa` gives that port and `gnt_pb` is 0.
- R4: Code 1 takes execution ports 0 and 1 if both are free, and otherwise 2 and 3 if both are free. Otherwise it takes nothing. `gnt_pa` is the lower port and `gnt_pb` is the upper port.
- R5: Code 2 takes the lowest free load port. `gnt_pa` gives that port and `gnt_pb` is 0.
- R6: Code 3 (branch, sync, or plain store) takes the lowest free store port. `gnt_pa` gives that port and `gnt_pb` is 0.
- R7: Code 4 takes the lowest free load port and the lowest free store port together, or neither of them. `gnt_pa` is the load port and `gnt_pb` is the store port.
- R8: Code 5 takes both store ports, only when both are free. `gnt_pa` is 0 and `gnt_pb` is 1.
- R9: Operations are considered in slot order. An older operation claims ports before any younger one. A younger operation may be granted from ports left over when an older one fails.
- R10: An operation that is not granted stays held with its code unchanged and is retried in the next cycle. A granted operation is never granted again.
- R11: In one cycle no port of any kind is booked by more than one granted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_vld | input | 8 | Per-operation valid of the offered group; bit i is slot i (0 oldest) |
| grp_code | input | 8x3 | Per-operation request code (0 exec, 1 exec pair, 2 load, 3 store, 4 load+store, 5 store pair, 6/7 exec) |
| grp_ready | output | 1 | Group is accepted on this edge if any valid bit is set |
| gnt | output | 8 | Per-slot grant this cycle |
| gnt_pa | output | 8x2 | Per-slot first port index (exec, load or store per code) |
| gnt_pb | output | 8x2 | Per-slot second port index (upper pair port or store port) |

## Verification
Several cases are aimed at specific mistakes:

- A single execution request placed ahead of a pair request shows whether the pair moves to ports 2+3. A design that splits pairs, or that drops the pair, shows a wrong index or no grant.
- A load+store request that follows two plain loads must take nothing. A design that books only its store half blocks a later store, and that store's grant goes missing.
- A store pair placed between two single stores must wait while the younger single store is granted. A design that stops at the first failure withholds that grant.
- Groups with gaps in their valid bits check for grants on empty slots.
- Long random groups check for double-booked ports, stale retries and readiness asserted early or late.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
  localparam logic [2:0] RQ_EX     = 3'd0;
  localparam logic [2:0] RQ_EXPAIR = 3'd1;
  localparam logic [2:0] RQ_LD     = 3'd2;
  localparam logic [2:0] RQ_ST     = 3'd3;
  localparam logic [2:0] RQ_LDST   = 3'd4;
  localparam logic [2:0] RQ_STPAIR = 3'd5;

  // lowest set bit among the first n bits, -1 if none
  function automatic int first_free(logic [7:0] m, int n);
    int r;
    r = -1;
    for (int j = n - 1; j >= 0; j--)
      if (m[j]) r = j;
    return r;
  endfunction

  // low index of the first aligned pair with both bits set, -1 if none
  function automatic int pair_pick(logic [7:0] m, int n);
    int r;
    r = -1;
    for (int p = n / 2 - 1; p >= 0; p--)
      if (m[2*p] && m[2*p+1]) r = 2 * p;
    return r;
  endfunction

  // true when all of the first n bits are set
  function automatic logic all_free(logic [7:0] m, int n);
    logic r;
    r = 1'b1;
    for (int j = 0; j < n; j++)
      if (!m[j]) r = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/ipa_window.sv
module ipa_window #(
  parameter int NOPS = 8,
  parameter int CW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NOPS-1:0]          grp_vld,
  input  logic [NOPS-1:0][CW-1:0]  grp_code,
  input  logic [NOPS-1:0]          gnt,
  output logic [NOPS-1:0]          slot_v,
  output logic [NOPS-1:0][CW-1:0]  slot_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v    <= '0;
      slot_code <= '0;
    end else if (load) begin
      slot_v    <= grp_vld;
      slot_code <= grp_code;
    end else begin
      slot_v    <= slot_v & ~gnt;
    end
  end
endmodule

// File: rtl/ipa_arbiter.sv
module ipa_arbiter
  import ipa_pkg::*;
#(
  parameter int NOPS = 8,
  parameter int CW   = 3,
  parameter int NEX  = 4,
  parameter int NLD  = 2,
  parameter int NST  = 2,
  parameter int IW   = 2
) (
  input  logic [NOPS-1:0]          slot_v,
  input  logic [NOPS-1:0][CW-1:0]  slot_code,
  output logic [NOPS-1:0]          gnt,
  output logic [NOPS-1:0][IW-1:0]  gnt_pa,
  output logic [NOPS-1:0][IW-1:0]  gnt_pb
);
  logic [NEX-1:0] ex_f;
  logic [NLD-1:0] ld_f;
  logic [NST-1:0] st_f;
  int k, k2;

  always_comb begin
    ex_f   = '1;
    ld_f   = '1;
    st_f   = '1;
    gnt    = '0;
    gnt_pa = '0;
    gnt_pb = '0;
    k      = -1;
    k2     = -1;
    for (int i = 0; i < NOPS; i++) begin
      if (slot_v[i]) begin
        case (3'(slot_code[i]))
          RQ_EXPAIR: begin
            k = pair_pick(8'(ex_f), NEX);
            if (k >= 0) begin
              gnt[i] = 1'b1;
              gnt_pa[i] = IW'(k);
              gnt_pb[i] = IW'(k + 1);
              ex_f[k] = 1'b0;
              ex_f[k+1] = 1'b0;
            end
          end
          RQ_LD: begin
            k = first_free(8'(ld_f), NLD);
            if (k >= 0) begin
              gnt[i] = 1'b1;
              gnt_pa[i] = IW'(k);
              ld_f[k] = 1'b0;
            end
          end
          RQ_ST: begin
            k = first_free(8'(st_f), NST);
            if (k >= 0) begin
              gnt[i] = 1'b1;
              gnt_pa[i] = IW'(k);
              st_f[k] = 1'b0;
            end
          end
          RQ_LDST: begin
            k  = first_free(8'(ld_f), NLD);
            k2 = first_free(8'(st_f), NST);
            if (k >= 0 && k2 >= 0) begin
              gnt[i] = 1'b1;
              gnt_pa[i] = IW'(k);
              gnt_pb[i] = IW'(k2);
              ld_f[k] = 1'b0;
              st_f[k2] = 1'b0;
            end
          end
          RQ_STPAIR: begin
            if (all_free(8'(st_f), NST)) begin
              gnt[i] = 1'b1;
              gnt_pa[i] = '0;
              gnt_pb[i] = IW'(NST - 1);
              st_f = '0;
            end
          end
          default: begin
            k = first_free(8'(ex_f), NEX);
            if (k >= 0) begin
              gnt[i] = 1'b1;
              gnt_pa[i] = IW'(k);
              ex_f[k] = 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ipa_top.sv
module ipa_top #(
  parameter int NOPS = 8,
  parameter int CW   = 3,
  parameter int NEX  = 4,
  parameter int NLD  = 2,
  parameter int NST  = 2,
  localparam int NMAX = (NEX > NLD) ? ((NEX > NST) ? NEX : NST) : ((NLD > NST) ? NLD : NST),
  localparam int IW   = (NMAX > 1) ? $clog2(NMAX) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NOPS-1:0]          grp_vld,
  input  logic [NOPS-1:0][CW-1:0]  grp_code,
  output logic                     grp_ready,
  output logic [NOPS-1:0]          gnt,
  output logic [NOPS-1:0][IW-1:0]  gnt_pa,
  output logic [NOPS-1:0][IW-1:0]  gnt_pb
);
  logic [NOPS-1:0]         slot_v;
  logic [NOPS-1:0][CW-1:0] slot_code;
  logic                    held_left;
  logic                    load;

  assign held_left = |(slot_v & ~gnt);
  assign grp_ready = ~held_left;
  assign load      = grp_ready & (|grp_vld);

  ipa_window #(.NOPS(NOPS), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .load(load), .grp_vld(grp_vld),
    .grp_code(grp_code), .gnt(gnt), .slot_v(slot_v), .slot_code(slot_code)
  );

  ipa_arbiter #(.NOPS(NOPS), .CW(CW), .NEX(NEX), .NLD(NLD), .NST(NST), .IW(IW)) u_arb (
    .slot_v(slot_v), .slot_code(slot_code), .gnt(gnt),
    .gnt_pa(gnt_pa), .gnt_pb(gnt_pb)
  );
endmodule

// File: rtl/ipa_chk.sv
module ipa_chk
  import ipa_pkg::*;
#(
  parameter int NOPS = 8,
  parameter int CW   = 3,
  parameter int NST  = 2,
  parameter int IW   = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load,
  input logic [NOPS-1:0]         grp_vld,
  input logic [NOPS-1:0]         slot_v,
  input logic [NOPS-1:0][CW-1:0] slot_code,
  input logic [NOPS-1:0]         gnt,
  input logic [NOPS-1:0][IW-1:0] gnt_pa,
  input logic [NOPS-1:0][IW-1:0] gnt_pb
);
  // R2
  load_takes_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> slot_v == $past(grp_vld));

  for (genvar i = 0; i < NOPS; i++) begin : g_slot
    // R2
    grant_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> slot_v[i]);
    // R10
    no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] && !load |=> !slot_v[i]);
    // R10
    held_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_v[i] && !gnt[i] |=> slot_v[i] && slot_code[i] == $past(slot_code[i]));
    // R8
    store_pair_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] && 3'(slot_code[i]) == RQ_STPAIR |-> gnt_pa[i] == '0 && gnt_pb[i] == IW'(NST - 1));
    // R4
    exec_pair_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] && 3'(slot_code[i]) == RQ_EXPAIR |-> !gnt_pa[i][0] && gnt_pb[i] == gnt_pa[i] + 1'b1);
  end
endmodule

bind ipa_top ipa_chk #(.NOPS(NOPS), .CW(CW), .NST(NST), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .grp_vld(grp_vld), .slot_v(slot_v),
  .slot_code(slot_code), .gnt(gnt), .gnt_pa(gnt_pa), .gnt_pb(gnt_pb)
);

// File: tb/ipa_top_test.sv
module ipa_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]      grp_vld = '0;
  logic [7:0][2:0] grp_code = '0;
  logic            grp_ready;
  logic [7:0]      gnt;
  logic [7:0][1:0] gnt_pa, gnt_pb;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipa_top uut (.clk(clk), .rst_n(rst_n), .grp_vld(grp_vld), .grp_code(grp_code),
               .grp_ready(grp_ready), .gnt(gnt), .gnt_pa(gnt_pa), .gnt_pb(gnt_pb));

  // bench model of held ops
  logic [7:0]      mv = '0;
  logic [7:0][2:0] mc = '0;

  // scoreboard queues
  logic [7:0]      q_g[$];
  logic [7:0][1:0] q_a[$], q_b[$];
  logic [7:0][2:0] q_c[$];
  logic            q_r[$];
  string           q_t[$];

  task automatic predict(output logic [7:0] g, output logic [7:0][1:0] a, output logic [7:0][1:0] b);
    bit [3:0] ef = 4'hF;
    bit [1:0] lf = 2'b11, sf = 2'b11;
    g = '0; a = '0; b = '0;
    for (int i = 0; i < 8; i++) begin
      if (mv[i]) begin
        case (mc[i])
          3'd1: if (ef[0] && ef[1]) begin g[i] = 1; a[i] = 0; b[i] = 1; ef[1:0] = 0; end
                else if (ef[2] && ef[3]) begin g[i] = 1; a[i] = 2; b[i] = 3; ef[3:2] = 0; end
          3'd2: if (lf[0]) begin g[i] = 1; a[i] = 0; lf[0] = 0; end
                else if (lf[1]) begin g[i] = 1; a[i] = 1; lf[1] = 0; end
          3'd3: if (sf[0]) begin g[i] = 1; a[i] = 0; sf[0] = 0; end
                else if (sf[1]) begin g[i] = 1; a[i] = 1; sf[1] = 0; end
          3'd4: if (lf != 0 && sf != 0) begin
                  g[i] = 1;
                  a[i] = lf[0] ? 2'd0 : 2'd1;
                  b[i] = sf[0] ? 2'd0 : 2'd1;
                  lf[a[i][0]] = 0; sf[b[i][0]] = 0;
                end
          3'd5: if (sf == 2'b11) begin g[i] = 1; a[i] = 0; b[i] = 1; sf = 0; end
          default: begin
            for (int p = 3; p >= 0; p--) if (ef[p]) a[i] = 2'(p);
            if (ef != 0) begin g[i] = 1; ef[a[i]] = 0; end
          end
        endcase
      end
    end
  endtask

  // driver: one cycle; returns whether the offered group was taken
  task automatic step(input logic [7:0] gv, input logic [7:0][2:0] gc, input string tag, output bit took);
    logic [7:0] g;
    logic [7:0][1:0] a, b;
    logic rdy;
    @(negedge clk);
    predict(g, a, b);
    rdy = ((mv & ~g) == 0);
    q_g.push_back(g); q_a.push_back(a); q_b.push_back(b);
    q_c.push_back(mc); q_r.push_back(rdy); q_t.push_back(tag);
    took = rdy && (gv != 0);
    if (took) begin
      grp_vld = gv; grp_code = gc; mv = gv; mc = gc;
    end else begin
      grp_vld = '0; mv = mv & ~g;
    end
  endtask

  task automatic send(input logic [7:0] gv, input logic [7:0][2:0] gc, input string tag);
    bit took = 0;
    while (!took) step(gv, gc, tag, took);
  endtask

  task automatic drain(input string tag);
    bit took;
    for (int n = 0; n < 4; n++) step('0, '0, tag, took);
  endtask

  function automatic logic [7:0][2:0] codes(input int c0, c1, c2, c3, c4, c5, c6, c7);
    logic [7:0][2:0] r;
    r[0] = 3'(c0); r[1] = 3'(c1); r[2] = 3'(c2); r[3] = 3'(c3);
    r[4] = 3'(c4); r[5] = 3'(c5); r[6] = 3'(c6); r[7] = 3'(c7);
    return r;
  endfunction

  // monitor
  initial begin
    logic [7:0] eg;
    logic [7:0][1:0] ea, eb;
    logic [7:0][2:0] ec;
    logic er;
    string t;
    bit bad;
    bit [3:0] ux;
    bit [1:0] ul, us;
    forever begin
      @(negedge clk); #1;
      while (q_g.size() > 0) begin
        eg = q_g.pop_front(); ea = q_a.pop_front(); eb = q_b.pop_front();
        ec = q_c.pop_front(); er = q_r.pop_front(); t = q_t.pop_front();
        n_chk++;
        bad = (gnt !== eg) || (grp_ready !== er);
        for (int i = 0; i < 8; i++)
          if (eg[i] && (gnt_pa[i] !== ea[i] || gnt_pb[i] !== eb[i])) bad = 1;
        if (bad) begin
          n_fail++;
          $display("FAIL %s gnt=%b pa=%h pb=%h rdy=%b expected gnt=%b pa=%h pb=%h rdy=%b",
                   t, gnt, gnt_pa, gnt_pb, grp_ready, eg, ea, eb, er);
        end
        // R11 booking check from the port outputs
        n_chk++;
        ux = 0; ul = 0; us = 0; bad = 0;
        for (int i = 0; i < 8; i++) begin
          if (gnt[i]) begin
            case (ec[i])
              3'd1: begin if (ux[gnt_pa[i]] || ux[gnt_pb[i]]) bad = 1; ux[gnt_pa[i]] = 1; ux[gnt_pb[i]] = 1; end
              3'd2: begin if (ul[gnt_pa[i][0]]) bad = 1; ul[gnt_pa[i][0]] = 1; end
              3'd3: begin if (us[gnt_pa[i][0]]) bad = 1; us[gnt_pa[i][0]] = 1; end
              3'd4: begin if (ul[gnt_pa[i][0]] || us[gnt_pb[i][0]]) bad = 1;
                          ul[gnt_pa[i][0]] = 1; us[gnt_pb[i][0]] = 1; end
              3'd5: begin if (us != 0) bad = 1; us = 2'b11; end
              default: begin if (ux[gnt_pa[i]]) bad = 1; ux[gnt_pa[i]] = 1; end
            endcase
          end
        end
        if (bad) begin
          n_fail++;
          $display("FAIL R11 port booked twice: gnt=%b pa=%h pb=%h expected no overlap", gnt, gnt_pa, gnt_pb);
        end
      end
    end
  end

  // stimulus
  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_chk++;
    if (gnt !== 8'h00 || grp_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 gnt=%b rdy=%b expected gnt=00000000 rdy=1", gnt, grp_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1 idle after reset, R3 eight singles: four now, four retried (R10)
    drain("R1");
    send(8'hFF, codes(0, 0, 0, 0, 0, 0, 6, 7), "R3 R10");
    drain("R10");
    // R4 single ahead of pairs: pair goes to 2+3, second pair waits
    send(8'h07, codes(0, 1, 1, 0, 0, 0, 0, 0), "R4 R9");
    drain("R4");
    send(8'h03, codes(1, 1, 0, 0, 0, 0, 0, 0), "R4");
    drain("R4");
    // R5 R7 three loads then load+store
    send(8'h0F, codes(2, 2, 2, 4, 0, 0, 0, 0), "R5 R7");
    drain("R7");
    // R6 R8 R9 single store, store pair, single store
    send(8'h07, codes(3, 5, 3, 0, 0, 0, 0, 0), "R6 R8 R9");
    drain("R8");
    // R7 all-or-none: load+store then store pair, then loads after load+store
    send(8'h03, codes(4, 5, 0, 0, 0, 0, 0, 0), "R7 R8");
    drain("R7");
    send(8'h1F, codes(2, 2, 4, 3, 3, 0, 0, 0), "R7 R9");
    drain("R7");
    // R2 sparse valid bits
    send(8'hA5, codes(1, 5, 1, 5, 1, 5, 1, 5), "R2");
    drain("R2");
    send(8'h80, codes(5, 5, 5, 5, 5, 5, 5, 5), "R2");
    drain("R2");
    // R11 R9 R10 random groups
    for (int n = 0; n < 300; n++) begin
      logic [7:0] v;
      logic [7:0][2:0] c;
      v = 8'($urandom_range(1, 255));
      for (int i = 0; i < 8; i++) c[i] = 3'($urandom_range(0, 7));
      send(v, c, "R11 R9 R10");
    end
    drain("R10");
    @(negedge clk); #2;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, expected the run to end");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule